// File: doc/BRIEF.md
# Strobe-Timed ADC Sampling Controller

This controller runs an external converter with a parallel result bus in an endless single-channel loop. It does not use the read strobe to set when sampling happens. A separate active-low start strobe does that instead: the falling edge of `start_n` opens the sampling window and the rising edge starts the conversion. Several converters can share one start strobe, so they all sample at the same instant. The read strobe is used only to move the finished word onto the bus.

Once a conversion has started, the controller waits for the end of the conversion. It can do this in one of two ways. In the first, it watches the converter's active-low interrupt, which passes through a two-flop synchronizer. In the second, it ignores the interrupt and waits a fixed number of cycles. After the wait it selects the converter, pulls the read strobe low, captures the bus and releases the converter. Every minimum time is a count of system clock cycles set by a parameter. A power-down flag selects the longer sampling window.

A watchdog limits how long the controller waits for the interrupt. If the interrupt never arrives, the controller raises an error pulse and abandons the conversion. The enable input is sampled only between conversions, so clearing it always lets the current read finish.

Top module: `adc_strobe_ctrl`

## Requirements
- R1: While `rst` is high and afterwards until `enable` is seen, `cs_n`, `start_n` and `rd_n` are 1 and `result_valid` and `irq_timeout_err` are 0. A reset in mid-loop returns all strobes to 1 on the next edge.
- R2: `start_n` stays low for exactly SAMPLE_NORM cycles (default 4) when `pd_mode`=0, and for exactly SAMPLE_PD cycles (default 24) when `pd_mode`=1.
- R3: In interrupt mode (`tmo_mode`=0), when the interrupt arrives early, `cs_n` falls exactly CONV_WAIT_MIN+IRQ_SETTLE cycles (default 22) after `start_n` rises.
- R4: In interrupt mode, when the interrupt arrives late, `cs_n` falls exactly IRQ_SETTLE+3 cycles (default 4) after `irq_n` goes low. Two of those cycles are the synchronizer.
- R5: In timeout mode (`tmo_mode`=1), `irq_n` has no effect, and `cs_n` falls exactly CONV_TIMEOUT cycles (default 21) after `start_n` rises.
- R6: `rd_n` falls one cycle after `cs_n` falls and stays low for exactly READ_SETUP cycles (default 2). `rd_n` is never low while `cs_n` is high.
- R7: `result` equals the `adc_data` value present while `rd_n` is low. `result_valid` is high for exactly one cycle, and that cycle is the one in which `rd_n` returns to 1.
- R8: `cs_n` returns to 1 one cycle after `rd_n` returns to 1.
- R9: In interrupt mode with no interrupt, `irq_timeout_err` pulses for one cycle exactly IRQ_LIMIT cycles (default 64) after `start_n` rises. During that conversion `cs_n` does not fall and `result_valid` does not pulse.
- R10: Clearing `enable` after a conversion has begun lets that conversion run through its read. No new `start_n` fall follows.
- R11: `start_n` and `cs_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the loop; sampled only between conversions |
| pd_mode | input | 1 | 1 selects the longer power-down sampling window |
| tmo_mode | input | 1 | 1 uses the fixed conversion timeout and ignores the interrupt |
| irq_n | input | 1 | Converter end-of-conversion interrupt, active low, asynchronous |
| adc_data | input | DATA_W | Converter parallel result bus |
| cs_n | output | 1 | Converter chip select, active low |
| start_n | output | 1 | Sample/convert start strobe, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| result | output | DATA_W | Last captured conversion word |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |
| irq_timeout_err | output | 1 | One-cycle pulse when the interrupt wait times out |

## Verification
The bench times every strobe edge against a converter model and checks the sampling window in both power modes. It also checks the interrupt path with an early interrupt and with a late one. With an early interrupt, a design that skipped the minimum wait would select the converter too soon. With a late interrupt, a design that dropped a synchronizer stage or the settle cycle would select the converter one cycle early. In timeout mode the model still raises the interrupt early, so a design that listened to it would select the converter before the timeout. The bench also starves the interrupt to check the watchdog, and clears enable mid-conversion: a design that aborted the read would lose the result, and one that ignored enable would start another sample.

// File: rtl/adc_strobe_pkg.sv
package adc_strobe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONVERT,
    ST_SETTLE,
    ST_SELECT,
    ST_READ,
    ST_RELEASE
  } phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_irq_sync.sv
module adc_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic sync_low
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], async_n};
  end

  assign sync_low = ~chain[STAGES-1];
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (~&cnt)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_strobe_ctrl.sv
module adc_strobe_ctrl
  import adc_strobe_pkg::*;
#(
  parameter int DATA_W        = 10,
  parameter int SAMPLE_NORM   = 4,
  parameter int SAMPLE_PD     = 24,
  parameter int CONV_WAIT_MIN = 21,
  parameter int CONV_TIMEOUT  = 21,
  parameter int IRQ_SETTLE    = 1,
  parameter int READ_SETUP    = 2,
  parameter int IRQ_LIMIT     = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pd_mode,
  input  logic              tmo_mode,
  input  logic              irq_n,
  input  logic [DATA_W-1:0] adc_data,
  output logic              cs_n,
  output logic              start_n,
  output logic              rd_n,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              irq_timeout_err
);
  localparam int LONGEST = max2(max2(max2(SAMPLE_NORM, SAMPLE_PD), max2(CONV_TIMEOUT, IRQ_LIMIT)),
                                max2(max2(CONV_WAIT_MIN, IRQ_SETTLE), READ_SETUP));
  localparam int CNT_W = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] LAST_NORM   = CNT_W'(SAMPLE_NORM - 1);
  localparam logic [CNT_W-1:0] LAST_PD     = CNT_W'(SAMPLE_PD - 1);
  localparam logic [CNT_W-1:0] LAST_TMO    = CNT_W'(CONV_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] LAST_MINW   = CNT_W'(CONV_WAIT_MIN - 1);
  localparam logic [CNT_W-1:0] LAST_WDOG   = CNT_W'(IRQ_LIMIT - 1);
  localparam logic [CNT_W-1:0] LAST_SETTLE = CNT_W'(IRQ_SETTLE - 1);
  localparam logic [CNT_W-1:0] LAST_READ   = CNT_W'(READ_SETUP - 1);

  phase_t           state, state_d;
  logic [CNT_W-1:0] cnt;
  logic             irq_low;
  logic             err_d, cap_d;
  logic [CNT_W-1:0] sample_last;

  adc_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_n(irq_n), .sync_low(irq_low)
  );

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(state_d != state), .cnt(cnt)
  );

  assign sample_last = pd_mode ? LAST_PD : LAST_NORM;

  always_comb begin
    state_d = state;
    err_d   = 1'b0;
    cap_d   = 1'b0;
    case (state)
      ST_IDLE:    if (enable) state_d = ST_SAMPLE;
      ST_SAMPLE:  if (cnt == sample_last) state_d = ST_CONVERT;
      ST_CONVERT: begin
        if (tmo_mode) begin
          if (cnt == LAST_TMO) state_d = ST_SELECT;
        end else if (irq_low && cnt >= LAST_MINW) begin
          state_d = ST_SETTLE;
        end else if (cnt == LAST_WDOG) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end
      end
      ST_SETTLE:  if (cnt == LAST_SETTLE) state_d = ST_SELECT;
      ST_SELECT:  state_d = ST_READ;
      ST_READ: begin
        if (cnt == LAST_READ) begin
          state_d = ST_RELEASE;
          cap_d   = 1'b1;
        end
      end
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      cs_n            <= 1'b1;
      start_n         <= 1'b1;
      rd_n            <= 1'b1;
      result          <= '0;
      result_valid    <= 1'b0;
      irq_timeout_err <= 1'b0;
    end else begin
      state           <= state_d;
      start_n         <= (state_d != ST_SAMPLE);
      cs_n            <= !(state_d == ST_SELECT || state_d == ST_READ || state_d == ST_RELEASE);
      rd_n            <= (state_d != ST_READ);
      result_valid    <= cap_d;
      irq_timeout_err <= err_d;
      if (cap_d) result <= adc_data;
    end
  end

  AST_NO_READ_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !cs_n); // R6
  AST_VALID_AT_READ_END: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $rose(rd_n)); // R7
  AST_START_SELECT_APART: assert property (@(posedge clk) disable iff (rst)
    !(!start_n && !cs_n)); // R11
  AST_WDOG_NO_READ: assert property (@(posedge clk) disable iff (rst)
    irq_timeout_err |-> (cs_n && rd_n && !result_valid)); // R9
  AST_READ_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> $past(!cs_n)); // R6
  AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $past(rd_n)); // R8
endmodule

// File: tb/adc_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module adc_strobe_ctrl_bench;
  localparam int DW = 10;
  localparam int NV = 5;
  // {pd_mode, tmo_mode, irq latency after start rise (0 = never), data}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'd5,  10'h155},
    {1'b1, 1'b0, 8'd5,  10'h2AA},
    {1'b0, 1'b0, 8'd40, 10'h3FF},
    {1'b0, 1'b1, 8'd3,  10'h001},
    {1'b1, 1'b1, 8'd0,  10'h200}
  };

  logic clk = 0, rst = 1, enable = 0, pd_mode = 0, tmo_mode = 0, irq_n = 1;
  logic [DW-1:0] adc_data = '0;
  logic cs_n, start_n, rd_n, result_valid, irq_timeout_err;
  logic [DW-1:0] result;

  adc_strobe_ctrl u_adc_strobe_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .pd_mode(pd_mode), .tmo_mode(tmo_mode),
    .irq_n(irq_n), .adc_data(adc_data), .cs_n(cs_n), .start_n(start_n), .rd_n(rd_n),
    .result(result), .result_valid(result_valid), .irq_timeout_err(irq_timeout_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model and edge monitor, both at the falling edge
  int m_lat = 0, pend = 0;
  logic [DW-1:0] m_data = '0, cap = '0;
  logic p_start = 1, p_cs = 1, p_rd = 1;
  int t_sfall, t_srise, t_irq, t_cfall, t_crise, t_rfall, t_rrise, t_valid, t_err;
  int n_sfall = 0, n_cfall = 0, n_valid = 0, n_err = 0;

  always @(negedge clk) begin
    if (p_start && !start_n) begin t_sfall = cyc; n_sfall++; irq_n = 1; pend = 0; end
    if (!p_start && start_n) begin t_srise = cyc; pend = m_lat; end
    else if (pend > 0) begin
      pend--;
      if (pend == 0) begin irq_n = 0; t_irq = cyc; end
    end
    if (p_cs && !cs_n) begin t_cfall = cyc; n_cfall++; end
    if (!p_cs && cs_n) t_crise = cyc;
    if (p_rd && !rd_n) t_rfall = cyc;
    if (!p_rd && rd_n) t_rrise = cyc;
    if (!rd_n) begin irq_n = 1; adc_data = m_data; end else adc_data = '0;
    if (result_valid) begin t_valid = cyc; n_valid++; cap = result; end
    if (irq_timeout_err) begin t_err = cyc; n_err++; end
    p_start = start_n; p_cs = cs_n; p_rd = rd_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  task automatic run_one(input logic pd, input logic tmo, input int lat, input logic [DW-1:0] d);
    int sb, vb, eb, cb, guard;
    sb = n_sfall; vb = n_valid; eb = n_err; cb = n_cfall;
    pd_mode = pd; tmo_mode = tmo; m_lat = lat; m_data = d;
    enable = 1;
    guard = 0;
    while (n_sfall == sb && guard < 50) begin tick(1); guard++; end
    enable = 0;                                   // R10: drop mid-conversion
    guard = 0;
    while (n_valid == vb && n_err == eb && guard < 300) begin tick(1); guard++; end
    tick(40);
    if (lat == 0 && tmo == 0) begin
      check(t_err - t_srise == 64, "R9 err delay", t_err - t_srise, 64);
      check(n_err - eb == 1, "R9 err pulse count", n_err - eb, 1);
      check(n_cfall == cb, "R9 no select", n_cfall - cb, 0);
      check(n_valid == vb, "R9 no valid", n_valid - vb, 0);
    end else begin
      check(t_srise - t_sfall == (pd ? 24 : 4), "R2 start low width", t_srise - t_sfall, pd ? 24 : 4);
      if (tmo)
        check(t_cfall - t_srise == 21, "R5 timeout select", t_cfall - t_srise, 21);
      else if (lat <= 18)
        check(t_cfall - t_srise == 22, "R3 min conversion wait", t_cfall - t_srise, 22);
      else
        check(t_cfall - t_irq == 4, "R4 irq to select", t_cfall - t_irq, 4);
      check(t_rfall - t_cfall == 1, "R6 select to read", t_rfall - t_cfall, 1);
      check(t_rrise - t_rfall == 2, "R6 read width", t_rrise - t_rfall, 2);
      check(t_crise - t_rrise == 1, "R8 release", t_crise - t_rrise, 1);
      check(n_valid - vb == 1 && t_valid == t_rrise, "R7 valid pulse", t_valid - t_rrise, 0);
      check(cap == d, "R7 result", int'(cap), int'(d));
      check(n_err == eb, "R9 no false error", n_err - eb, 0);
    end
    check(n_sfall - sb == 1 && start_n, "R10 clean stop", n_sfall - sb, 1);
  endtask

  initial begin
    tick(3);
    check(cs_n && start_n && rd_n && !result_valid && !irq_timeout_err, "R1 reset outputs",
          {cs_n, start_n, rd_n, result_valid, irq_timeout_err}, 5'b11100);
    rst = 0;
    tick(10);
    check(start_n && n_sfall == 0, "R1 idle without enable", n_sfall, 0);

    for (int i = 0; i < NV; i++)
      run_one(VEC[i][19], VEC[i][18], int'(VEC[i][17:10]), VEC[i][9:0]);

    // R9: interrupt never arrives
    run_one(1'b0, 1'b0, 0, 10'h0AB);

    // R1: reset while sampling
    m_lat = 5; tmo_mode = 0; pd_mode = 1;
    enable = 1;
    tick(4);
    check(!start_n, "R1 sampling before reset", start_n, 0);
    rst = 1; enable = 0;
    tick(1);
    check(cs_n && start_n && rd_n, "R1 mid-loop reset", {cs_n, start_n, rd_n}, 3'b111);
    rst = 0;
    tick(5);
    finish_run();
  end
endmodule